// File: doc/BRIEF.md
# Comparator Edge Flag Conditioner

This block takes the single-bit decision of an analog comparator and turns it into status and interrupt information for the rest of the chip. The raw decision is high when the non-inverting input is above the inverting input and low otherwise. It first passes through a synchronizer. A polarity control can then flip it. The resulting conditioned level is always visible on a status pin.

Low-to-high and high-to-low transitions of the conditioned level each set their own sticky flag. A flag stays set until software clears it with a one-cycle write-1 strobe. Each flag has its own interrupt enable. The interrupt request is a registered OR of the enabled flags.

All pins are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure to manage.

Top module: `cmp_edge_flags`

## Requirements
- R1: While `rst_n` is low, and until the first input change has travelled through the pipeline, `rise_flag`, `fall_flag` and `irq` are 0. `out_level` equals `invert`, because the synchronizer resets to 0.
- R2: `out_level` equals the synchronized `cmp_raw` XOR `invert`. A change on `cmp_raw` shows on `out_level` after exactly two rising clock edges.
- R3: When the conditioned level goes from 0 to 1, `rise_flag` is 1 after the next rising clock edge, which is three edges after the `cmp_raw` change.
- R4: When the conditioned level goes from 1 to 0, `fall_flag` is 1 after the next rising clock edge, which is three edges after the `cmp_raw` change.
- R5: Changing `invert` while the synchronized input is steady sets neither flag.
- R6: A set flag stays 1 until a clock edge that samples its clear strobe (`clr_rise` or `clr_fall`) at 1 with no new edge. That edge clears it to 0. A strobe of 0 has no effect.
- R7: If a clear strobe and a new edge of the same kind meet at one clock edge, the flag is 1 afterwards.
- R8: After each clock edge, `irq` equals (`rise_flag` AND `rise_ie`) OR (`fall_flag` AND `fall_ie`), using the values present before that edge.
- R9: A flag whose enable is 0 never raises `irq`, even while it is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw comparator decision, 1 when + input is above − input |
| invert | input | 1 | 1 flips the polarity of the conditioned level |
| rise_ie | input | 1 | Interrupt enable for the rising-edge flag |
| fall_ie | input | 1 | Interrupt enable for the falling-edge flag |
| clr_rise | input | 1 | Write-1-to-clear strobe for the rising-edge flag |
| clr_fall | input | 1 | Write-1-to-clear strobe for the falling-edge flag |
| out_level | output | 1 | Conditioned comparator level |
| rise_flag | output | 1 | Sticky rising-edge flag |
| fall_flag | output | 1 | Sticky falling-edge flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded properties check the flag rules on every cycle:
- a set wins over a clear,
- a flag holds without a clear,
- a clear with no new edge drops the flag,
- a polarity change on a steady input produces no edge,
- `irq` stays quiet when no flag was set.

Other behaviour can only be shown by the bench's scenarios, which compare against a cycle model:
- the exact two- and three-edge latencies from `cmp_raw` to the status pins,
- the effect of each enable on `irq`,
- the reset state.

// File: rtl/cmp_edge_flags_pkg.sv
package cmp_edge_flags_pkg;
  typedef enum logic {EDGE_UP = 1'b0, EDGE_DOWN = 1'b1} edge_kind_e;
  localparam int unsigned NUM_KINDS = 2;
  localparam int unsigned DEF_SYNC = 2;
endpackage

// File: rtl/cef_sync.sv
module cef_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/cef_edge.sv
module cef_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic invert_i,
  output logic level_o,
  output logic up_o,
  output logic down_o
);
  logic prev_raw_q;
  logic prev_cond;

  // The previous sample is kept in raw polarity. Both sides of the
  // comparison therefore see the same invert value in the same cycle.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_raw_q <= 1'b0;
    else        prev_raw_q <= sync_i;

  assign level_o   = sync_i ^ invert_i;
  assign prev_cond = prev_raw_q ^ invert_i;
  assign up_o      = level_o & ~prev_cond;
  assign down_o    = ~level_o & prev_cond;

  // R5
  inv_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(invert_i) && $stable(sync_i)) |-> (!up_o && !down_o));
endmodule

// File: rtl/cef_flag.sv
module cef_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;

  assign flag_o = flag_q;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  // R6
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/cmp_edge_flags.sv
module cmp_edge_flags
  import cmp_edge_flags_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_raw,
  input  logic invert,
  input  logic rise_ie,
  input  logic fall_ie,
  input  logic clr_rise,
  input  logic clr_fall,
  output logic out_level,
  output logic rise_flag,
  output logic fall_flag,
  output logic irq
);
  logic                 synced;
  logic                 ev_up, ev_down;
  logic [NUM_KINDS-1:0] ev_vec, clr_vec, flag_vec, ie_vec;
  logic                 irq_q;

  cef_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_raw), .q_o(synced)
  );

  cef_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sync_i(synced), .invert_i(invert),
    .level_o(out_level), .up_o(ev_up), .down_o(ev_down)
  );

  assign ev_vec[EDGE_UP]    = ev_up;
  assign ev_vec[EDGE_DOWN]  = ev_down;
  assign clr_vec[EDGE_UP]   = clr_rise;
  assign clr_vec[EDGE_DOWN] = clr_fall;
  assign ie_vec[EDGE_UP]    = rise_ie;
  assign ie_vec[EDGE_DOWN]  = fall_ie;

  genvar k;
  generate
    for (k = 0; k < NUM_KINDS; k++) begin : g_flag
      cef_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(ev_vec[k]),
        .clr_i(clr_vec[k]), .flag_o(flag_vec[k])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(flag_vec & ie_vec);

  assign rise_flag = flag_vec[EDGE_UP];
  assign fall_flag = flag_vec[EDGE_DOWN];
  assign irq       = irq_q;

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_flag && !fall_flag) |=> !irq);
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_ie && !fall_ie) |=> !irq);
endmodule

// File: tb/cmp_edge_flags_bench.sv
module cmp_edge_flags_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp_raw = 0, invert = 0, rise_ie = 0, fall_ie = 0, clr_rise = 0, clr_fall = 0;
  logic out_level, rise_flag, fall_flag, irq;

  int total = 0, bad = 0;
  bit finished = 0;

  // Cycle model state, built from the requirements.
  logic m_s1 = 0, m_s2 = 0, m_prev = 0, m_rf = 0, m_ff = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_edge_flags u_cmp_edge_flags (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .invert(invert),
    .rise_ie(rise_ie), .fall_ie(fall_ie), .clr_rise(clr_rise), .clr_fall(clr_fall),
    .out_level(out_level), .rise_flag(rise_flag), .fall_flag(fall_flag), .irq(irq)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic up_ev(logic s2, logic pv, logic inv);
    return (s2 ^ inv) & ~(pv ^ inv);
  endfunction

  function automatic logic down_ev(logic s2, logic pv, logic inv);
    return ~(s2 ^ inv) & (pv ^ inv);
  endfunction

  task automatic tick(input logic raw, input logic inv, input logic rie,
                      input logic fie, input logic cr, input logic cf);
    logic u, d;
    cmp_raw = raw; invert = inv; rise_ie = rie; fall_ie = fie;
    clr_rise = cr; clr_fall = cf;
    @(posedge clk);
    u = up_ev(m_s2, m_prev, inv);
    d = down_ev(m_s2, m_prev, inv);
    m_irq  = (m_rf & rie) | (m_ff & fie);
    m_rf   = u | (m_rf & ~cr);
    m_ff   = d | (m_ff & ~cf);
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = raw;
    @(negedge clk);
    check(out_level, m_s2 ^ inv, "R2 out_level");
    check(rise_flag, m_rf, "R3 rise_flag");
    check(fall_flag, m_ff, "R4 fall_flag");
    check(irq, m_irq, "R8 irq");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    invert = 1'b1;
    #(CLK_PERIOD * 3 + 2);
    // R1: reset state
    check(rise_flag, 1'b0, "R1 rise_flag in reset");
    check(fall_flag, 1'b0, "R1 fall_flag in reset");
    check(irq, 1'b0, "R1 irq in reset");
    check(out_level, 1'b1, "R1 out_level equals invert");
    invert = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R3: a raw rise shows on the level after 2 edges and on the flag after 3
    tick(1, 0, 1, 0, 0, 0);
    check(out_level, 1'b0, "R2 level not yet after 1 edge");
    tick(1, 0, 1, 0, 0, 0);
    check(out_level, 1'b1, "R2 level after 2 edges");
    check(rise_flag, 1'b0, "R3 flag not yet");
    tick(1, 0, 1, 0, 0, 0);
    check(rise_flag, 1'b1, "R3 flag after 3 edges");
    tick(1, 0, 1, 0, 0, 0);
    check(irq, 1'b1, "R8 irq follows enabled rise flag");

    // R6: a strobe of 0 keeps the flag, a strobe of 1 clears it
    tick(1, 0, 1, 0, 0, 0);
    check(rise_flag, 1'b1, "R6 flag sticky");
    tick(1, 0, 1, 0, 1, 0);
    check(rise_flag, 1'b0, "R6 flag cleared");

    // R5: toggling invert on a steady input sets no flag
    tick(1, 1, 1, 1, 0, 0);
    tick(1, 0, 1, 1, 0, 0);
    tick(1, 1, 1, 1, 0, 0);
    check(rise_flag, 1'b0, "R5 no rise on invert toggle");
    check(fall_flag, 1'b0, "R5 no fall on invert toggle");

    // R4 and R9: with invert=1, a raw rise is a falling conditioned edge; fall_ie is 0
    tick(0, 1, 1, 0, 0, 0);
    tick(0, 1, 1, 0, 0, 0);
    tick(0, 1, 1, 0, 0, 0);
    check(rise_flag, 1'b1, "R3 rise flag from inverted raw fall");
    tick(0, 1, 0, 0, 1, 0);
    tick(1, 1, 0, 0, 0, 0);
    tick(1, 1, 0, 0, 0, 0);
    tick(1, 1, 0, 0, 0, 0);
    check(fall_flag, 1'b1, "R4 fall flag set");
    tick(1, 1, 0, 0, 0, 0);
    tick(1, 1, 0, 0, 0, 0);
    check(irq, 1'b0, "R9 masked fall flag gives no irq");

    // R7: a clear strobe that meets a new fall edge leaves the flag set
    tick(0, 1, 0, 0, 0, 0);
    tick(0, 1, 0, 0, 0, 0);
    tick(0, 1, 0, 0, 0, 1);
    tick(1, 1, 0, 0, 0, 0);
    tick(1, 1, 0, 0, 0, 0);
    tick(1, 1, 0, 0, 0, 1);
    check(fall_flag, 1'b1, "R7 set wins over clear");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic r, v;
      r = ($urandom % 4 == 0) ? ~cmp_raw : cmp_raw;
      v = ($urandom % 16 == 0) ? ~invert : invert;
      tick(r, v, $urandom % 2, $urandom % 2, ($urandom % 5 == 0), ($urandom % 5 == 0));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule